// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block sits on the device side of an asynchronous DRAM control interface. It samples the row strobe, the per-byte column strobes and the write enable on a fast system clock. From the order in which these lines change, it works out what kind of memory cycle the controller is running. Classification uses only edge order and sample counts: whether the column strobe was already low when the row strobe fell, where the write enable fell relative to the column strobe, and how long the strobes stayed low. It tells apart reads, early writes, read-modify-writes, row-only refreshes, column-before-row refreshes, hidden refreshes and entry into self refresh.

When a cycle completes, the block gives one valid pulse together with a cycle code, a byte-lane mask and the access index within the open row. Three single-cycle violation pulses flag a badly timed write enable, a hidden refresh whose column strobe was released too early, and a row strobe held low too long. A level output shows that the device is in self refresh. The block can serve as a bus checker, or as the control front end of a DRAM behavioural model.

All strobes are active low. The inputs are assumed to be synchronous to the sampling clock.

Top module: `dram_cycle_monitor`

## Requirements
- R1: While reset is held, and on the first sample after it, cyc_valid, self_ref and all three violation pulses are 0.
- R2: A row strobe falling while every column strobe is high opens a row. If the row strobe rises with no column strobe fall in between, one report follows with cycle code 3 (row-only refresh), lane mask 0 and index 0. A row closed after one or more accesses gives no extra report.
- R3: A row strobe falling while any column strobe is low starts a column-before-row refresh. Code 4 is reported, with lane mask 0, when the row strobe rises.
- R4: The device enters self refresh when, in a column-before-row refresh, the row strobe and a column strobe both stay low for more than SELF_CYC samples. Code 6 is reported and self_ref rises. self_ref stays 1 while the row strobe is low, whatever the column strobes do, and clears on the sample where the row strobe is high.
- R5: Write enable low on the sample where the first column strobe falls marks an early write. It is reported as code 0x1 when the access ends.
- R6: Write enable high at the column fall marks a read, code 0. Write enable falling while a column strobe is still low, at least ACC_CYC samples after the column fall, turns the access into a read-modify-write, code 2. A fall sooner than that pulses viol_we and leaves the code at 0.
- R7: Consider a row strobe that rises while a column strobe is still low; this rise reports the access. If the row strobe then falls again with the column strobe still low, that is a hidden refresh. It is reported as code 5 when the row strobe rises, provided the column strobe stayed low for at least HOLD_CYC samples after the second fall. If the column strobe is released earlier, viol_hold pulses and no code-5 report follows.
- R8: cyc_lanes bit 0 is the lower byte (cas_n[0]) and bit 1 is the upper byte (cas_n[1]). A bit is set when that strobe was low during the access.
- R9: Every further column fall while the row strobe stays low is reported as its own access. cyc_page counts 1, 2, 3 ... within the row.
- R10: A row strobe low for more than RAS_MAX_CYC samples in a normal row or a hidden refresh gives exactly one viol_ras_long pulse. It never pulses during a column-before-row refresh or self refresh.
- R11: Each report appears on the clock after the completing sample, and cyc_valid lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Column strobes, one per byte lane, active low; bit 0 is the lower byte |
| we_n | input | 1 | Write enable, active low |
| cyc_valid | output | 1 | One-cycle pulse when a cycle is reported |
| cyc_type | output | 3 | Cycle code: 0 read, 1 early write, 2 read-modify-write, 3 row-only refresh, 4 column-before-row refresh, 5 hidden refresh, 6 self-refresh entry |
| cyc_lanes | output | LANES | Byte lanes used by the reported access |
| cyc_page | output | PAGE_W | Access index within the open row |
| self_ref | output | 1 | High while in self refresh |
| viol_we | output | 1 | Pulse: write enable fell before the read access time |
| viol_hold | output | 1 | Pulse: column strobe released too early in a hidden refresh |
| viol_ras_long | output | 1 | Pulse: row strobe held low too long |

## Verification
The end of a column access and the close of its row can happen on the same sample, when the column strobe and the row strobe rise together. In that case the block must give exactly one access report, with the right code, lanes and index, and no row-only report. The stimulus table drives both strobes high in one sample after an early write. The check then requires a single valid pulse carrying code 1, both lanes and index 1, and no valid on the following sample. A second overlap is checked as well: the self-refresh and long-row timers run on the same counter, so the self-refresh entry test counts every viol_ras_long pulse and expects none.

// File: rtl/dram_mon_pkg.sv
`timescale 1ns/1ps
// Shared types of the DRAM cycle classifier: reported cycle codes and tracker states.
package dram_mon_pkg;
    typedef enum logic [2:0] {
        CYC_READ    = 3'd0,
        CYC_EWRITE  = 3'd1,
        CYC_RMW     = 3'd2,
        CYC_RASONLY = 3'd3,
        CYC_CBR     = 3'd4,
        CYC_HIDDEN  = 3'd5,
        CYC_SELF    = 3'd6
    } cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ROW, ST_TAIL, ST_HID, ST_CBR, ST_SELF
    } st_e;
endpackage

// File: rtl/dram_mon_edges.sv
`timescale 1ns/1ps
// Strobe edge detector.
// Compares each pin with its value on the previous sample and produces level
// and edge events per lane. Assumes pins are synchronous to clk. All strobes
// reset to their inactive (high) level.
module dram_mon_edges #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             we_n,
    output logic             ras_low,
    output logic             ras_fall,
    output logic             ras_rise,
    output logic [LANES-1:0] lane_low,
    output logic             cas_any_low,
    output logic             cas_any_fall,
    output logic             cas_all_rise,
    output logic             we_fall
);
    logic             ras_q;
    logic             we_q;
    logic [LANES-1:0] prev_low;

    // Hold previous samples of row strobe and write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            we_q  <= we_n;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic lane_q;
        // Hold previous sample of this lane's column strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) lane_q <= 1'b1;
            else        lane_q <= cas_n[i];
        end
        assign lane_low[i] = ~cas_n[i];
        assign prev_low[i] = ~lane_q;
    end

    assign ras_low      = ~ras_n;
    assign ras_fall     = ras_q & ~ras_n;
    assign ras_rise     = ~ras_q & ras_n;
    assign cas_any_low  = |lane_low;
    assign cas_any_fall = ~(|prev_low) & cas_any_low;
    assign cas_all_rise = (|prev_low) & ~cas_any_low;
    assign we_fall      = we_q & ~we_n;
endmodule

// File: rtl/dram_mon_timer.sv
`timescale 1ns/1ps
// Saturating low-time counter.
// Loads 1 on restart, then counts each enabled sample up to MAX and holds there.
// The value equals the number of enabled samples since restart, capped at MAX.
module dram_mon_timer #(
    parameter int MAX = 15,
    parameter int W   = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         enable,
    output logic [W-1:0] count
);
    // Count samples since restart, saturating at MAX.
    always_ff @(posedge clk) begin
        if (!rst_n)                               count <= '0;
        else if (restart)                         count <= W'(1);
        else if (enable && count != W'(MAX))      count <= count + W'(1);
    end

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= W'(MAX)) else $error("timer above limit"); // R4
endmodule

// File: rtl/dram_mon_fsm.sv
`timescale 1ns/1ps
// Cycle tracker.
// Follows the strobe edge order, classifies each cycle and drives the registered
// report and violation outputs. Assumes the timers restart on the row strobe fall
// and on the first column strobe fall respectively.
module dram_mon_fsm
    import dram_mon_pkg::*;
#(
    parameter int LANES       = 2,
    parameter int PAGE_W      = 8,
    parameter int ACC_CYC     = 10,
    parameter int HOLD_CYC    = 2,
    parameter int SELF_CYC    = 75000,
    parameter int RAS_MAX_CYC = 18750,
    parameter int RW          = 17,
    parameter int AW          = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_low,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic [LANES-1:0]  lane_low,
    input  logic              cas_any_low,
    input  logic              cas_any_fall,
    input  logic              cas_all_rise,
    input  logic              we_low,
    input  logic              we_fall,
    input  logic [RW-1:0]     ras_cnt,
    input  logic [AW-1:0]     acc_cnt,
    output logic              cyc_valid,
    output logic [2:0]        cyc_type,
    output logic [LANES-1:0]  cyc_lanes,
    output logic [PAGE_W-1:0] cyc_page,
    output logic              self_ref,
    output logic              viol_we,
    output logic              viol_hold,
    output logic              viol_ras_long
);
    localparam logic [RW-1:0]     SELF_L   = RW'(SELF_CYC);
    localparam logic [RW-1:0]     LONG_L   = RW'(RAS_MAX_CYC);
    localparam logic [RW-1:0]     HOLD_L   = RW'(HOLD_CYC);
    localparam logic [AW-1:0]     ACC_L    = AW'(ACC_CYC);
    localparam logic [PAGE_W-1:0] PAGE_TOP = '1;

    st_e               state;
    cyc_e              acc_type;
    cyc_e              out_type;
    logic [LANES-1:0]  lanes;
    logic [PAGE_W-1:0] page;
    logic              hid_ok;
    logic              cbr_ok;
    logic              hid_break;

    // Column strobe released before the hidden-refresh hold time elapsed.
    assign hid_break = (state == ST_HID) && hid_ok && !cas_any_low && (ras_cnt < HOLD_L);

    // Track cycle state and register one report per completed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            acc_type      <= CYC_READ;
            out_type      <= CYC_READ;
            lanes         <= '0;
            page          <= '0;
            hid_ok        <= 1'b0;
            cbr_ok        <= 1'b0;
            cyc_valid     <= 1'b0;
            cyc_lanes     <= '0;
            cyc_page      <= '0;
            self_ref      <= 1'b0;
            viol_we       <= 1'b0;
            viol_hold     <= 1'b0;
            viol_ras_long <= 1'b0;
        end else begin
            cyc_valid     <= 1'b0;
            viol_we       <= 1'b0;
            viol_hold     <= 1'b0;
            viol_ras_long <= 1'b0;
            if ((state == ST_ROW || state == ST_HID) && ras_low && ras_cnt == LONG_L)
                viol_ras_long <= 1'b1;
            case (state)
                ST_IDLE: if (ras_fall) begin
                    if (cas_any_low) begin
                        state  <= ST_CBR;
                        cbr_ok <= 1'b1;
                    end else begin
                        state <= ST_ROW;
                        page  <= '0;
                    end
                end
                ST_ROW: begin
                    if (cas_any_fall) begin
                        if (page != PAGE_TOP) page <= page + PAGE_W'(1);
                        acc_type <= we_low ? CYC_EWRITE : CYC_READ;
                        lanes    <= lane_low;
                    end else if (cas_any_low) begin
                        lanes <= lanes | lane_low;
                        if (we_fall && acc_type == CYC_READ) begin
                            if (acc_cnt >= ACC_L) acc_type <= CYC_RMW;
                            else                  viol_we  <= 1'b1;
                        end
                    end
                    if (cas_all_rise || (ras_rise && cas_any_low)) begin
                        cyc_valid <= 1'b1;
                        out_type  <= acc_type;
                        cyc_lanes <= lanes;
                        cyc_page  <= page;
                    end
                    if (ras_rise) begin
                        if (cas_any_low) state <= ST_TAIL;
                        else begin
                            state <= ST_IDLE;
                            if (page == '0) begin
                                cyc_valid <= 1'b1;
                                out_type  <= CYC_RASONLY;
                                cyc_lanes <= '0;
                                cyc_page  <= '0;
                            end
                        end
                    end
                end
                ST_TAIL: begin
                    if (ras_fall) begin
                        if (cas_any_low) begin
                            state  <= ST_HID;
                            hid_ok <= 1'b1;
                        end else begin
                            state <= ST_ROW;
                            page  <= '0;
                        end
                    end else if (!cas_any_low) state <= ST_IDLE;
                end
                ST_HID: begin
                    if (hid_break) begin
                        hid_ok    <= 1'b0;
                        viol_hold <= 1'b1;
                    end
                    if (ras_rise) begin
                        if (hid_ok && !hid_break) begin
                            cyc_valid <= 1'b1;
                            out_type  <= CYC_HIDDEN;
                            cyc_lanes <= '0;
                            cyc_page  <= '0;
                        end
                        state <= cas_any_low ? ST_TAIL : ST_IDLE;
                    end
                end
                ST_CBR: begin
                    if (!cas_any_low) cbr_ok <= 1'b0;
                    if (ras_rise) begin
                        cyc_valid <= 1'b1;
                        out_type  <= CYC_CBR;
                        cyc_lanes <= '0;
                        cyc_page  <= '0;
                        state     <= ST_IDLE;
                    end else if (cbr_ok && cas_any_low && ras_cnt >= SELF_L) begin
                        cyc_valid <= 1'b1;
                        out_type  <= CYC_SELF;
                        cyc_lanes <= '0;
                        cyc_page  <= '0;
                        self_ref  <= 1'b1;
                        state     <= ST_SELF;
                    end
                end
                ST_SELF: if (ras_rise) begin
                    self_ref <= 1'b0;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cyc_type = out_type;

    AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |=> !cyc_valid) else $error("valid longer than one cycle"); // R11
    AST_SELF_ENTRY_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(self_ref) |-> (cyc_valid && cyc_type == CYC_SELF)) else $error("silent self entry"); // R4
    AST_SELF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (self_ref && ras_rise) |=> !self_ref) else $error("self refresh not left"); // R4
    AST_ACCESS_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type <= 3'd2) |-> (cyc_lanes != '0)) else $error("access without lane"); // R8
    AST_NO_LONG_IN_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        self_ref |-> !viol_ras_long) else $error("long-row flag in self refresh"); // R10
endmodule

// File: rtl/dram_cycle_monitor.sv
`timescale 1ns/1ps
// DRAM strobe cycle classifier, top level.
// Samples the row strobe, per-byte column strobes and write enable on clk,
// classifies each memory cycle and reports it with a one-cycle valid pulse.
// Assumes the strobe pins are already synchronous to clk.
module dram_cycle_monitor #(
    parameter int LANES       = 2,
    parameter int PAGE_W      = 8,
    parameter int ACC_CYC     = 10,
    parameter int HOLD_CYC    = 2,
    parameter int SELF_CYC    = 75000,
    parameter int RAS_MAX_CYC = 18750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic [LANES-1:0]  cas_n,
    input  logic              we_n,
    output logic              cyc_valid,
    output logic [2:0]        cyc_type,
    output logic [LANES-1:0]  cyc_lanes,
    output logic [PAGE_W-1:0] cyc_page,
    output logic              self_ref,
    output logic              viol_we,
    output logic              viol_hold,
    output logic              viol_ras_long
);
    localparam int RAS_TOP = ((SELF_CYC > RAS_MAX_CYC) ? SELF_CYC : RAS_MAX_CYC) + 1;
    localparam int RW      = $clog2(RAS_TOP + 1);
    localparam int AW      = $clog2(ACC_CYC + 1);

    logic             ras_low, ras_fall, ras_rise;
    logic [LANES-1:0] lane_low;
    logic             cas_any_low, cas_any_fall, cas_all_rise, we_fall;
    logic [RW-1:0]    ras_cnt;
    logic [AW-1:0]    acc_cnt;

    dram_mon_edges #(.LANES(LANES)) u_edges (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ras_low(ras_low), .ras_fall(ras_fall), .ras_rise(ras_rise),
        .lane_low(lane_low), .cas_any_low(cas_any_low), .cas_any_fall(cas_any_fall),
        .cas_all_rise(cas_all_rise), .we_fall(we_fall)
    );

    dram_mon_timer #(.MAX(RAS_TOP), .W(RW)) u_ras_timer (
        .clk(clk), .rst_n(rst_n), .restart(ras_fall), .enable(ras_low), .count(ras_cnt)
    );

    dram_mon_timer #(.MAX(ACC_CYC), .W(AW)) u_acc_timer (
        .clk(clk), .rst_n(rst_n), .restart(cas_any_fall), .enable(cas_any_low), .count(acc_cnt)
    );

    dram_mon_fsm #(
        .LANES(LANES), .PAGE_W(PAGE_W), .ACC_CYC(ACC_CYC), .HOLD_CYC(HOLD_CYC),
        .SELF_CYC(SELF_CYC), .RAS_MAX_CYC(RAS_MAX_CYC), .RW(RW), .AW(AW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .ras_low(ras_low), .ras_fall(ras_fall), .ras_rise(ras_rise),
        .lane_low(lane_low), .cas_any_low(cas_any_low), .cas_any_fall(cas_any_fall),
        .cas_all_rise(cas_all_rise), .we_low(~we_n), .we_fall(we_fall),
        .ras_cnt(ras_cnt), .acc_cnt(acc_cnt),
        .cyc_valid(cyc_valid), .cyc_type(cyc_type), .cyc_lanes(cyc_lanes), .cyc_page(cyc_page),
        .self_ref(self_ref), .viol_we(viol_we), .viol_hold(viol_hold), .viol_ras_long(viol_ras_long)
    );
endmodule

// File: tb/test_dram_cycle_monitor.sv
`timescale 1ns/1ps
module test_dram_cycle_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1;
    logic [1:0] cas_n = 2'b11;
    logic       we_n = 1'b1;
    logic       cyc_valid;
    logic [2:0] cyc_type;
    logic [1:0] cyc_lanes;
    logic [7:0] cyc_page;
    logic       self_ref, viol_we, viol_hold, viol_ras_long;
    int         nchk = 0;
    int         nerr = 0;
    int         long_seen = 0;

    always #2 clk = ~clk;

    dram_cycle_monitor #(
        .LANES(2), .PAGE_W(8), .ACC_CYC(3), .HOLD_CYC(2), .SELF_CYC(40), .RAS_MAX_CYC(30)
    ) i_dram_cycle_monitor (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cyc_valid(cyc_valid), .cyc_type(cyc_type), .cyc_lanes(cyc_lanes), .cyc_page(cyc_page),
        .self_ref(self_ref), .viol_we(viol_we), .viol_hold(viol_hold), .viol_ras_long(viol_ras_long)
    );

    typedef struct packed {
        logic       ras;
        logic [1:0] cas;
        logic       we;
        logic       ev;
        logic [2:0] ty;
        logic [1:0] ln;
        logic [3:0] pg;
        logic [3:0] rq;
    } vec_t;

    // Per-sample stimulus and the report expected right after that sample.
    localparam int NV = 37;
    localparam vec_t VEC [NV] = '{
        // R2 row opened and closed without column access
        '{1'b0,2'b11,1'b1,1'b0,3'd0,2'b00,4'd0,4'd2},
        '{1'b0,2'b11,1'b1,1'b0,3'd0,2'b00,4'd0,4'd2},
        '{1'b1,2'b11,1'b1,1'b1,3'd3,2'b00,4'd0,4'd2},
        '{1'b1,2'b11,1'b1,1'b0,3'd0,2'b00,4'd0,4'd2},
        // R6 R9 word read, then fast-page accesses; R8 lanes; R5 early write
        '{1'b0,2'b11,1'b1,1'b0,3'd0,2'b00,4'd0,4'd6},
        '{1'b0,2'b00,1'b1,1'b0,3'd0,2'b00,4'd0,4'd6},
        '{1'b0,2'b00,1'b1,1'b0,3'd0,2'b00,4'd0,4'd6},
        '{1'b0,2'b11,1'b1,1'b1,3'd0,2'b11,4'd1,4'd6},
        '{1'b0,2'b10,1'b1,1'b0,3'd0,2'b00,4'd0,4'd8},
        '{1'b0,2'b11,1'b1,1'b1,3'd0,2'b01,4'd2,4'd8},
        '{1'b0,2'b01,1'b0,1'b0,3'd0,2'b00,4'd0,4'd5},
        '{1'b0,2'b11,1'b1,1'b1,3'd1,2'b10,4'd3,4'd5},
        // R6 read-modify-write after the access time, R9 index 4
        '{1'b0,2'b00,1'b1,1'b0,3'd0,2'b00,4'd0,4'd6},
        '{1'b0,2'b00,1'b1,1'b0,3'd0,2'b00,4'd0,4'd6},
        '{1'b0,2'b00,1'b1,1'b0,3'd0,2'b00,4'd0,4'd6},
        '{1'b0,2'b00,1'b0,1'b0,3'd0,2'b00,4'd0,4'd6},
        '{1'b0,2'b11,1'b1,1'b1,3'd2,2'b11,4'd4,4'd9},
        '{1'b1,2'b11,1'b1,1'b0,3'd0,2'b00,4'd0,4'd2},
        // R3 column-before-row refresh
        '{1'b1,2'b00,1'b1,1'b0,3'd0,2'b00,4'd0,4'd3},
        '{1'b0,2'b00,1'b1,1'b0,3'd0,2'b00,4'd0,4'd3},
        '{1'b0,2'b00,1'b1,1'b0,3'd0,2'b00,4'd0,4'd3},
        '{1'b1,2'b00,1'b1,1'b1,3'd4,2'b00,4'd0,4'd3},
        '{1'b1,2'b11,1'b1,1'b0,3'd0,2'b00,4'd0,4'd3},
        // R7 hidden refresh after a read
        '{1'b0,2'b11,1'b1,1'b0,3'd0,2'b00,4'd0,4'd7},
        '{1'b0,2'b00,1'b1,1'b0,3'd0,2'b00,4'd0,4'd7},
        '{1'b0,2'b00,1'b1,1'b0,3'd0,2'b00,4'd0,4'd7},
        '{1'b1,2'b00,1'b1,1'b1,3'd0,2'b11,4'd1,4'd7},
        '{1'b1,2'b00,1'b1,1'b0,3'd0,2'b00,4'd0,4'd7},
        '{1'b0,2'b00,1'b1,1'b0,3'd0,2'b00,4'd0,4'd7},
        '{1'b0,2'b00,1'b1,1'b0,3'd0,2'b00,4'd0,4'd7},
        '{1'b0,2'b00,1'b1,1'b0,3'd0,2'b00,4'd0,4'd7},
        '{1'b1,2'b00,1'b1,1'b1,3'd5,2'b00,4'd0,4'd7},
        '{1'b1,2'b11,1'b1,1'b0,3'd0,2'b00,4'd0,4'd7},
        // R11 column end and row close on one sample: one report only
        '{1'b0,2'b11,1'b1,1'b0,3'd0,2'b00,4'd0,4'd11},
        '{1'b0,2'b00,1'b0,1'b0,3'd0,2'b00,4'd0,4'd11},
        '{1'b1,2'b11,1'b1,1'b1,3'd1,2'b11,4'd1,4'd11},
        '{1'b1,2'b11,1'b1,1'b0,3'd0,2'b00,4'd0,4'd11}
    };

    task automatic step(input logic r, input logic [1:0] c, input logic w);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w;
        @(posedge clk);
        #1;
        long_seen += int'(viol_ras_long);
    endtask

    task automatic check(input string rq, input string what, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) step(1'b1, 2'b11, 1'b1);
        check("R1", "valid", cyc_valid, 0);
        check("R1", "self_ref", self_ref, 0);
        check("R1", "violations", {viol_we, viol_hold, viol_ras_long}, 0);
        rst_n = 1'b1;
        step(1'b1, 2'b11, 1'b1);
        check("R1", "valid after reset", cyc_valid, 0);

        // Stimulus table
        for (int i = 0; i < NV; i++) begin
            string tag;
            step(VEC[i].ras, VEC[i].cas, VEC[i].we);
            tag = $sformatf("R%0d row%0d", VEC[i].rq, i);
            check(tag, "valid", cyc_valid, VEC[i].ev);
            if (VEC[i].ev) begin
                check(tag, "type", cyc_type, VEC[i].ty);
                check(tag, "lanes", cyc_lanes, VEC[i].ln);
                check(tag, "page", cyc_page, VEC[i].pg);
            end
        end

        // R6 write enable falls before access time: flagged, stays a read
        step(1'b0, 2'b11, 1'b1);
        step(1'b0, 2'b00, 1'b1);
        step(1'b0, 2'b00, 1'b0);
        check("R6", "viol_we", viol_we, 1);
        step(1'b0, 2'b11, 1'b1);
        check("R6", "viol_we pulse end", viol_we, 0);
        check("R6", "early-we type", cyc_type, 0);
        check("R6", "early-we valid", cyc_valid, 1);
        step(1'b1, 2'b11, 1'b1);

        // R7 hidden refresh with column strobe released too early
        step(1'b0, 2'b11, 1'b1);
        step(1'b0, 2'b00, 1'b1);
        step(1'b1, 2'b00, 1'b1);
        check("R7", "tail access report", cyc_valid, 1);
        step(1'b0, 2'b00, 1'b1);
        step(1'b0, 2'b11, 1'b1);
        check("R7", "viol_hold", viol_hold, 1);
        step(1'b1, 2'b11, 1'b1);
        check("R7", "no hidden report", cyc_valid, 0);
        step(1'b1, 2'b11, 1'b1);

        // R10 long row: one pulse after RAS_MAX_CYC+1 low samples
        long_seen = 0;
        step(1'b0, 2'b11, 1'b1);
        repeat (29) step(1'b0, 2'b11, 1'b1);
        check("R10", "no flag at limit", viol_ras_long, 0);
        step(1'b0, 2'b11, 1'b1);
        check("R10", "flag past limit", viol_ras_long, 1);
        repeat (15) step(1'b0, 2'b11, 1'b1);
        check("R10", "single pulse", long_seen, 1);
        step(1'b1, 2'b11, 1'b1);
        check("R2", "row-only after long row", cyc_type, 3);
        step(1'b1, 2'b11, 1'b1);

        // R4 self refresh entry, hold with column strobes released, exit
        long_seen = 0;
        step(1'b1, 2'b00, 1'b1);
        step(1'b0, 2'b00, 1'b1);
        repeat (39) step(1'b0, 2'b00, 1'b1);
        check("R4", "not yet in self refresh", self_ref, 0);
        step(1'b0, 2'b00, 1'b1);
        check("R4", "entry valid", cyc_valid, 1);
        check("R4", "entry type", cyc_type, 6);
        check("R4", "self_ref set", self_ref, 1);
        repeat (5) step(1'b0, 2'b11, 1'b1);
        check("R4", "held with CAS high", self_ref, 1);
        step(1'b1, 2'b11, 1'b1);
        check("R4", "exit on RAS high", self_ref, 0);
        check("R10", "no long flag in self refresh", long_seen, 0);
        step(1'b1, 2'b11, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule